// File: doc/BRIEF.md
# Pseudo-SRAM Byte-Lane Access Controller

This controller sits between a simple synchronous host port and a 64K x 16 nonvolatile memory that has an asynchronous pseudo-SRAM pin interface. The memory captures the address and write data on the falling edge of its write or output strobe, so it is not level-sensitive like a true SRAM. Each access therefore needs a setup phase, a strobe pulse and then a precharge phase with both strobes high before the next access can start. The controller produces that pin sequence from one host request. The strobe-low and precharge-high durations are parameters counted in clock cycles.

The host raises `req_valid` with the access type, the word address, the write data and a two-bit byte enable (bit 0 selects bits 7:0, bit 1 selects bits 15:8). It holds these until `rsp_ready` pulses for one cycle. For a read, `rsp_rdata` is valid from that cycle until the next read finishes. The state machine has five states:
- `ST_IDLE` waits for a request. It moves to `ST_SETUP`, or to `ST_ACK` when the byte enable is zero.
- `ST_SETUP` selects the chip, presents the address, byte strobes and write data for one cycle, then moves to `ST_STROBE`.
- `ST_STROBE` holds the write or output strobe low for `STROBE_CYC` cycles, then moves to `ST_PRECH`.
- `ST_PRECH` deselects the chip with both strobes high for `PRECH_CYC` cycles, then moves to `ST_ACK`.
- `ST_ACK` raises `rsp_ready` for one cycle and returns to `ST_IDLE`.

Top module: `psram_lane_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, the chip is deselected (`mem_ce1_n`=1, `mem_ce2`=0), `mem_we_n`, `mem_oe_n`, `mem_lb_n` and `mem_ub_n` are 1, `mem_dq_oe` is 0 and `rsp_ready` is 0.
- R2: The chip is selected (`mem_ce1_n`=0 and `mem_ce2`=1) for exactly one setup cycle plus the strobe cycles of each access with a nonzero byte enable, and is deselected at all other times.
- R3: A write request with a nonzero byte enable produces exactly one low pulse on `mem_we_n` while `mem_oe_n` stays high. Only the lanes whose enable bit is 1 are written (bit 0 drives `mem_lb_n` low, bit 1 drives `mem_ub_n` low).
- R4: A read request with a nonzero byte enable produces exactly one low pulse on `mem_oe_n` while `mem_we_n` stays high. `rsp_rdata` returns the memory byte on each enabled lane and 8'h00 on each disabled lane.
- R5: The address, byte strobes and write data settle at least one cycle before the strobe falls, and they stay unchanged until it rises.
- R6: Each strobe low pulse lasts exactly `STROBE_CYC` clock cycles.
- R7: After the strobe rises, both strobes stay high for exactly `PRECH_CYC` cycles before `rsp_ready` asserts. A request with a nonzero byte enable completes `2+STROBE_CYC+PRECH_CYC` cycles after `ST_IDLE` accepts it.
- R8: A request with byte enable 2'b00 gets `rsp_ready` in the cycle after it is accepted. It produces no strobe, no chip select and no change to memory.
- R9: `rsp_ready` is a single-cycle pulse for both reads and writes.
- R10: `mem_dq_oe` is 1 only during the setup and strobe cycles of a write, and it is never 1 while `mem_oe_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request, held until `rsp_ready` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables: bit 0 = low byte, bit 1 = high byte |
| rsp_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, disabled lanes are zero |
| mem_ce1_n | output | 1 | Chip select, active low |
| mem_ce2 | output | 1 | Chip select, active high |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output strobe, active low |
| mem_lb_n | output | 1 | Low byte strobe, active low |
| mem_ub_n | output | 1 | High byte strobe, active low |
| mem_addr | output | 16 | Memory address |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_in | input | 16 | Data from the memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |

## Verification
The assertions assume that the host keeps `req_valid` and its request fields steady from the cycle it raises them until the `rsp_ready` pulse, and that it makes no new request in the cycle of that pulse. The bench drives every request from one task that does exactly this. The task drops `req_valid` in the cycle it sees `rsp_ready`, and it starts the next request at least one cycle later. The memory model in the bench reacts only to strobe edges, so the strobe-width and precharge properties are the only timing rules it relies on.

// File: rtl/psc_pkg.sv
package psc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_PRECH,
        ST_ACK
    } psc_state_e;
endpackage

// File: rtl/psc_timer.sv
module psc_timer #(
    parameter int MAXV = 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  logic [$clog2(MAXV+1)-1:0]     load_val,
    output logic                          last
);
    localparam int TW = $clog2(MAXV + 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/psc_datapath.sv
module psc_datapath #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  capture,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic [DATA_W/8-1:0]   req_be,
    input  logic                  rd_sample,
    input  logic [DATA_W-1:0]     dq_in,
    output logic [ADDR_W-1:0]     addr_q,
    output logic [DATA_W-1:0]     wdata_q,
    output logic [DATA_W/8-1:0]   be_q,
    output logic                  write_q,
    output logic [DATA_W-1:0]     rdata_q
);
    localparam int LANES = DATA_W / 8;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
            write_q <= 1'b0;
        end else if (capture) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            be_q    <= req_be;
            write_q <= req_write;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] lane_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                lane_q <= '0;
            else if (rd_sample)
                lane_q <= be_q[g] ? dq_in[g*8 +: 8] : 8'h00;
        end
        assign rdata_q[g*8 +: 8] = lane_q;
    end
endmodule

// File: rtl/psram_lane_ctrl.sv
module psram_lane_ctrl #(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 16,
    parameter int STROBE_CYC = 2,
    parameter int PRECH_CYC  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic [DATA_W/8-1:0]   req_be,
    output logic                  rsp_ready,
    output logic [DATA_W-1:0]     rsp_rdata,
    output logic                  mem_ce1_n,
    output logic                  mem_ce2,
    output logic                  mem_we_n,
    output logic                  mem_oe_n,
    output logic                  mem_lb_n,
    output logic                  mem_ub_n,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [DATA_W-1:0]     mem_dq_out,
    input  logic [DATA_W-1:0]     mem_dq_in,
    output logic                  mem_dq_oe
);
    import psc_pkg::*;

    localparam int LANES  = DATA_W / 8;
    localparam int MAXCYC = (STROBE_CYC > PRECH_CYC) ? STROBE_CYC : PRECH_CYC;
    localparam int TW     = $clog2(MAXCYC + 1);
    localparam logic [TW-1:0] STRB_LOAD = TW'(STROBE_CYC - 1);
    localparam logic [TW-1:0] PRCH_LOAD = TW'(PRECH_CYC - 1);

    psc_state_e state_q, state_d;

    logic              tmr_load;
    logic [TW-1:0]     tmr_val;
    logic              tmr_last;
    logic              capture;
    logic              rd_sample;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  be_q;
    logic              write_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next state and timer control
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = STRB_LOAD;
        capture  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    capture = 1'b1;
                    state_d = (req_be == '0) ? ST_ACK : ST_SETUP;
                end
            end
            ST_SETUP: begin
                tmr_load = 1'b1;
                tmr_val  = STRB_LOAD;
                state_d  = ST_STROBE;
            end
            ST_STROBE: begin
                if (tmr_last) begin
                    tmr_load = 1'b1;
                    tmr_val  = PRCH_LOAD;
                    state_d  = ST_PRECH;
                end
            end
            ST_PRECH: begin
                if (tmr_last)
                    state_d = ST_ACK;
            end
            ST_ACK: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign rd_sample = (state_q == ST_STROBE) && tmr_last && !write_q;

    // pin outputs
    always_comb begin
        mem_ce1_n = 1'b1;
        mem_ce2   = 1'b0;
        mem_we_n  = 1'b1;
        mem_oe_n  = 1'b1;
        mem_lb_n  = 1'b1;
        mem_ub_n  = 1'b1;
        mem_dq_oe = 1'b0;
        rsp_ready = 1'b0;
        unique case (state_q)
            ST_SETUP, ST_STROBE: begin
                mem_ce1_n = 1'b0;
                mem_ce2   = 1'b1;
                mem_lb_n  = !be_q[0];
                mem_ub_n  = !be_q[LANES-1];
                mem_dq_oe = write_q;
                if (state_q == ST_STROBE) begin
                    mem_we_n = !write_q;
                    mem_oe_n = write_q;
                end
            end
            ST_ACK:   rsp_ready = 1'b1;
            ST_IDLE, ST_PRECH: ;
            default: ;
        endcase
    end

    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;

    psc_timer #(.MAXV(MAXCYC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    psc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_be    (req_be),
        .rd_sample (rd_sample),
        .dq_in     (mem_dq_in),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q),
        .be_q      (be_q),
        .write_q   (write_q),
        .rdata_q   (rsp_rdata)
    );
endmodule

// File: rtl/psc_chk.sv
module psc_chk #(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 16,
    parameter int STROBE_CYC = 2,
    parameter int PRECH_CYC  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_ce1_n,
    input logic              mem_ce2,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_lb_n,
    input logic              mem_ub_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe,
    input logic              rsp_ready
);
    logic        strb_n;
    logic [15:0] lo_cnt;
    logic [15:0] hi_cnt;

    assign strb_n = mem_we_n && mem_oe_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_cnt <= '0;
            hi_cnt <= '1;
        end else if (!strb_n) begin
            lo_cnt <= lo_cnt + 1'b1;
            hi_cnt <= '0;
        end else begin
            lo_cnt <= '0;
            if (hi_cnt != '1)
                hi_cnt <= hi_cnt + 1'b1;
        end
    end

    // R2
    select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strb_n |-> (!mem_ce1_n && mem_ce2));

    // R3
    we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_n || mem_oe_n);

    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strb_n |-> ($stable(mem_addr) && $stable(mem_lb_n) && $stable(mem_ub_n)
                     && $stable(mem_dq_out) && $stable(mem_dq_oe)));

    // R6
    strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strb_n) |-> (lo_cnt == 16'(STROBE_CYC)));

    // R7
    precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |-> (hi_cnt >= 16'(PRECH_CYC)));

    // R9
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |=> !rsp_ready);

    // R10
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_oe);
endmodule

bind psram_lane_ctrl psc_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STROBE_CYC(STROBE_CYC), .PRECH_CYC(PRECH_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_ce1_n  (mem_ce1_n),
    .mem_ce2    (mem_ce2),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_lb_n   (mem_lb_n),
    .mem_ub_n   (mem_ub_n),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .rsp_ready  (rsp_ready)
);

// File: tb/sim_psram_lane_ctrl.sv
`timescale 1ns/1ps
module sim_psram_lane_ctrl;
    localparam int S = 2;
    localparam int P = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        rsp_ready;
    logic [15:0] rsp_rdata;
    logic        mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n;
    logic [15:0] mem_addr, mem_dq_out, mem_dq_in;
    logic        mem_dq_oe;

    logic [15:0] model_mem [256];
    logic [15:0] ref_mem   [256];
    logic [7:0]  rd_lat = '0;
    int          n_total = 0;
    int          n_fail  = 0;
    bit          finished = 1'b0;

    always #4 clk = ~clk;

    psram_lane_ctrl #(.STROBE_CYC(S), .PRECH_CYC(P)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
        .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
        .mem_dq_oe(mem_dq_oe)
    );

    // memory model: edge-latched on strobe fall, low 8 address bits alias
    always @(negedge mem_we_n) begin
        if (!mem_ce1_n && mem_ce2 && mem_dq_oe) begin
            if (!mem_lb_n) model_mem[mem_addr[7:0]][7:0]  = mem_dq_out[7:0];
            if (!mem_ub_n) model_mem[mem_addr[7:0]][15:8] = mem_dq_out[15:8];
        end
    end

    always @(negedge mem_oe_n) rd_lat = mem_addr[7:0];

    always_comb begin
        mem_dq_in = 16'h5A5A;
        if (!mem_ce1_n && mem_ce2 && !mem_oe_n && mem_we_n) begin
            if (!mem_lb_n) mem_dq_in[7:0]  = model_mem[rd_lat][7:0];
            if (!mem_ub_n) mem_dq_in[15:8] = model_mem[rd_lat][15:8];
        end
    end

    function automatic logic [15:0] exp_read(input logic [15:0] w, input logic [1:0] be);
        return {be[1] ? w[15:8] : 8'h00, be[0] ? w[7:0] : 8'h00};
    endfunction

    function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d,
                                          input logic [1:0] be);
        return {be[1] ? d[15:8] : old[15:8], be[0] ? d[7:0] : old[7:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_op(input bit wr, input logic [15:0] a, input logic [15:0] d,
                         input logic [1:0] be);
        int lat = 0, lo = 0, falls = 0, sel = 0, oecyc = 0, hi_after = 0;
        int wrong_kind = 0, lane_bad = 0, addr_bad = 0, data_bad = 0;
        bit prev_low = 1'b0;
        bit hung = 1'b0;
        logic [15:0] exp_rd;
        exp_rd = exp_read(ref_mem[a[7:0]], be);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        forever begin
            @(negedge clk);
            lat++;
            if (!mem_we_n || !mem_oe_n) begin
                lo++;
                if (!prev_low) falls++;
                hi_after = 0;
                if (wr ? !(!mem_we_n && mem_oe_n) : !(!mem_oe_n && mem_we_n)) wrong_kind++;
                if (mem_lb_n != !be[0] || mem_ub_n != !be[1]) lane_bad++;
                if (mem_addr != a) addr_bad++;
                if (wr && mem_dq_out != d) data_bad++;
                prev_low = 1'b1;
            end else begin
                if (falls > 0 && !rsp_ready) hi_after++;
                prev_low = 1'b0;
            end
            if (!mem_ce1_n && mem_ce2) sel++;
            if (mem_dq_oe) oecyc++;
            if (rsp_ready) break;
            if (lat > 100) begin hung = 1'b1; break; end
        end
        req_valid = 1'b0;
        chk(!hung, "R9 completion watchdog", lat, 0);
        if (be == 2'b00) begin
            // R8
            chk(lat == 1 && falls == 0 && sel == 0, "R8 zero-enable completes at once",
                lat*256 + falls*16 + sel, 256);
        end else begin
            // R7
            chk(lat == 2 + S + P, "R7 latency", lat, 2 + S + P);
            chk(hi_after == P, "R7 precharge cycles", hi_after, P);
            // R6
            chk(falls == 1 && lo == S, "R6 one strobe pulse of STROBE_CYC", falls*256 + lo, 256 + S);
            // R2
            chk(sel == 1 + S, "R2 select cycles", sel, 1 + S);
            // R3 R4 R5
            chk(wrong_kind == 0 && lane_bad == 0, "R3/R4 strobe kind and lanes",
                wrong_kind*256 + lane_bad, 0);
            chk(addr_bad == 0 && data_bad == 0, "R5 address/data during strobe",
                addr_bad*256 + data_bad, 0);
            // R10
            chk(oecyc == (wr ? 1 + S : 0), "R10 drive cycles", oecyc, wr ? 1 + S : 0);
        end
        if (wr)
            ref_mem[a[7:0]] = merge(ref_mem[a[7:0]], d, be);
        else if (be != 2'b00)
            chk(rsp_rdata == exp_rd, "R4 read data", rsp_rdata, exp_rd);
        @(negedge clk);
        // R9
        chk(!rsp_ready, "R9 single-cycle ready", rsp_ready, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            model_mem[i] = 16'(i * 16'h0101) ^ 16'h3C5A;
            ref_mem[i]   = 16'(i * 16'h0101) ^ 16'h3C5A;
        end
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1
        chk(mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n
            && !mem_dq_oe && !rsp_ready, "R1 reset outputs",
            {mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe, rsp_ready},
            8'b10111100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_ready,
            "R1 idle after reset", {mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n}, 4'b1011);

        // directed byte-lane cases (R3 R4)
        do_op(1'b1, 16'h0012, 16'hBEEF, 2'b11);
        do_op(1'b0, 16'h0012, 16'h0000, 2'b11);
        do_op(1'b1, 16'h0012, 16'h1234, 2'b01);
        do_op(1'b0, 16'h0012, 16'h0000, 2'b11);
        do_op(1'b1, 16'h0012, 16'hAB00, 2'b10);
        do_op(1'b0, 16'h0012, 16'h0000, 2'b01);
        do_op(1'b0, 16'h0012, 16'h0000, 2'b10);
        // R8: zero enable leaves memory untouched
        do_op(1'b1, 16'h0012, 16'h0000, 2'b00);
        do_op(1'b0, 16'h0012, 16'h0000, 2'b00);
        do_op(1'b0, 16'h0012, 16'h0000, 2'b11);
        chk(rsp_rdata == 16'hAB34, "R8 memory unchanged after zero enable", rsp_rdata, 16'hAB34);
        // high address bits reach the pins (R5)
        do_op(1'b1, 16'hFF03, 16'hC0DE, 2'b11);
        do_op(1'b0, 16'hFF03, 16'h0000, 2'b11);

        for (int k = 0; k < 200; k++) begin
            logic [15:0] a;
            logic [15:0] d;
            logic [1:0]  be;
            bit          wr;
            a  = {8'($urandom()), 4'h0, 4'($urandom())};
            d  = 16'($urandom());
            be = 2'($urandom());
            wr = 1'($urandom());
            do_op(wr, a, d, be);
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end
endmodule